// File: doc/BRIEF.md
# GPIO Port with Mask/Set/Clear

This block is one general-purpose I/O port of up to 32 pins. Software reaches it through a simple register bus that completes every access in one cycle. The port holds a direction bit and an output data bit for each pin. It drives a pin only where that pin's direction bit is 1.

The output latch can be written in four ways:

- as a whole word;
- through a write-one-to-set address;
- through a write-one-to-clear address;
- through a masked-port address that touches only the bits the mask register enables.

Each of these is one bus write, so any group of outputs changes at once with no read-modify-write. Pin levels pass through a two-flop synchronizer before software can read them.

The bus interface uses these signals: `bus_sel`, `bus_wr`, `bus_addr`, `bus_wdata`, `bus_rdata`. A write takes effect at the rising edge where `bus_sel` and `bus_wr` are both high. `bus_rdata` is a combinational function of `bus_addr` and the current register state.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is asserted, and after it is released, the direction, output and mask registers hold 0. `pin_oe` and `pin_out` are therefore 0, so every pin is an input.
- R2: A write to address 1 loads the whole output latch with `bus_wdata`. A read of address 1 returns the latched output value.
- R3: A write to address 5 sets every output bit written as 1 and leaves bits written as 0 unchanged. A read of address 5 returns the output latch.
- R4: A write to address 6 clears every output bit written as 1 and leaves bits written as 0 unchanged. A read of address 6 returns the output latch.
- R5: The mask register (address 3) is read/write. Bit value 0 means the bit takes part in masked access. A write to address 4 copies `bus_wdata` into the output latch only at bits whose mask bit is 0; the other bits are unchanged.
- R6: A read of address 4 returns the synchronized pin levels at bits whose mask bit is 0, and 0 at masked-out bits.
- R7: The direction register (address 0) is read/write, with one bit per pin. `pin_oe` equals the direction register. `pin_out` equals the output latch ANDed with the direction register.
- R8: A read of address 2 returns the pin levels through a two-flop synchronizer. A change on `pin_in` set up before a rising edge is visible after the second rising edge, and not after the first.
- R9: Writes to address 2 and to the unmapped address 7 change no register. A read of address 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, combinational from address and register state |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Output level, forced to 0 where the pin is an input |
| pin_oe | output | WIDTH | Per-pin output enable |

## Verification
Register writes become visible on `bus_rdata`, `pin_out` and `pin_oe` one rising edge after the write cycle. Pin levels reach the pin-read and masked-read addresses two rising edges after `pin_in` changes. The bench drives inputs on falling edges and samples 2 ns later. It therefore checks a written register in the cycle after the write, and a pin read after exactly one edge (old value expected) and after two edges (new value expected). Checks after reset allow three edges for the synchronized reset release.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_DIR   = 3'd0,
    RA_OUT   = 3'd1,
    RA_PIN   = 3'd2,
    RA_MASK  = 3'd3,
    RA_MPORT = 3'd4,
    RA_SET   = 3'd5,
    RA_CLR   = 3'd6,
    RA_NONE  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_port_rst_sync.sv
module gpio_port_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]      wdata,
  output logic [WIDTH-1:0]      dir_q,
  output logic [WIDTH-1:0]      out_q,
  output logic [WIDTH-1:0]      mask_q
);
  reg_addr_e        sel_a;
  logic             dir_en, out_en, mask_en;
  logic [WIDTH-1:0] dir_d, out_d, mask_d;

  assign sel_a = reg_addr_e'(addr);

  always_comb begin
    dir_en  = wr_en && (sel_a == RA_DIR);
    mask_en = wr_en && (sel_a == RA_MASK);
    out_en  = 1'b0;
    dir_d   = wdata;
    mask_d  = wdata;
    out_d   = out_q;
    if (wr_en) begin
      unique case (sel_a)
        RA_OUT:   begin out_en = 1'b1; out_d = wdata;                             end
        RA_SET:   begin out_en = 1'b1; out_d = out_q | wdata;                     end
        RA_CLR:   begin out_en = 1'b1; out_d = out_q & ~wdata;                    end
        RA_MPORT: begin out_en = 1'b1; out_d = (out_q & mask_q) | (wdata & ~mask_q); end
        default:  begin out_en = 1'b0; out_d = out_q;                             end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      mask_q <= '0;
    end else begin
      if (dir_en)  dir_q  <= dir_d;
      if (out_en)  out_q  <= out_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  AST_WHOLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_a == RA_OUT) |=> out_q == $past(wdata)); // R2
  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_a == RA_SET) |=> ((out_q & $past(wdata)) == $past(wdata))
      && ((out_q ^ $past(out_q)) & ~$past(wdata)) == '0); // R3
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_a == RA_CLR) |=> ((out_q & $past(wdata)) == '0)
      && ((out_q ^ $past(out_q)) & ~$past(wdata)) == '0); // R4
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_a == RA_MPORT) |=> (((out_q ^ $past(out_q)) & $past(mask_q)) == '0)
      && (((out_q ^ $past(wdata)) & ~$past(mask_q)) == '0)); // R5
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (sel_a == RA_PIN || sel_a == RA_NONE))
      |=> $stable(out_q) && $stable(dir_q) && $stable(mask_q)); // R9
endmodule

// File: rtl/gpio_port_rdmux.sv
module gpio_port_rdmux
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]      dir_q,
  input  logic [WIDTH-1:0]      out_q,
  input  logic [WIDTH-1:0]      mask_q,
  input  logic [WIDTH-1:0]      pin_s,
  output logic [WIDTH-1:0]      rdata
);
  always_comb begin
    unique case (reg_addr_e'(addr))
      RA_DIR:                 rdata = dir_q;
      RA_OUT, RA_SET, RA_CLR: rdata = out_q;
      RA_PIN:                 rdata = pin_s;
      RA_MASK:                rdata = mask_q;
      RA_MPORT:               rdata = pin_s & ~mask_q;
      default:                rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]      bus_wdata,
  output logic [WIDTH-1:0]      bus_rdata,
  input  logic [WIDTH-1:0]      pin_in,
  output logic [WIDTH-1:0]      pin_out,
  output logic [WIDTH-1:0]      pin_oe
);
  logic             rst_n_s;
  logic             wr_en;
  logic [WIDTH-1:0] dir_q, out_q, mask_q, pin_s;

  assign wr_en = bus_sel && bus_wr;

  gpio_port_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .din(pin_in), .dout(pin_s)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .addr(bus_addr),
    .wdata(bus_wdata), .dir_q(dir_q), .out_q(out_q), .mask_q(mask_q)
  );

  gpio_port_rdmux #(.WIDTH(WIDTH)) u_rd (
    .addr(bus_addr), .dir_q(dir_q), .out_q(out_q), .mask_q(mask_q),
    .pin_s(pin_s), .rdata(bus_rdata)
  );

  assign pin_oe  = dir_q;
  assign pin_out = out_q & dir_q;

  AST_IDLE_IN_RESET: assert property (@(posedge clk)
    !rst_n_s |-> (pin_oe == '0) && (pin_out == '0)); // R1
  AST_NO_DRIVE_INPUT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pin_out & ~pin_oe) == '0); // R7
endmodule

// File: tb/gpio_mask_port_tb_top.sv
module gpio_mask_port_tb_top;
  localparam int unsigned W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0, pin_in = '0;
  logic [W-1:0]  bus_rdata, pin_out, pin_oe;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  gpio_mask_port #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd0, 32'hFFFF0000, 32'h0,        8'd7},
    '{1'b0, 3'd0, 32'h0,        32'hFFFF0000, 8'd7}, // R7 direction readback
    '{1'b1, 3'd1, 32'h12345678, 32'h0,        8'd2},
    '{1'b0, 3'd1, 32'h0,        32'h12345678, 8'd2}, // R2 whole load
    '{1'b1, 3'd5, 32'h0000000F, 32'h0,        8'd3},
    '{1'b0, 3'd1, 32'h0,        32'h1234567F, 8'd3}, // R3 set
    '{1'b0, 3'd5, 32'h0,        32'h1234567F, 8'd3}, // R3 read via set addr
    '{1'b1, 3'd6, 32'h12300000, 32'h0,        8'd4},
    '{1'b0, 3'd6, 32'h0,        32'h0004567F, 8'd4}, // R4 clear
    '{1'b1, 3'd3, 32'hFFFF00FF, 32'h0,        8'd5},
    '{1'b0, 3'd3, 32'h0,        32'hFFFF00FF, 8'd5}, // R5 mask readback
    '{1'b1, 3'd4, 32'hAAAAAAAA, 32'h0,        8'd5},
    '{1'b0, 3'd1, 32'h0,        32'h0004AA7F, 8'd5}, // R5 masked write
    '{1'b1, 3'd2, 32'hFFFFFFFF, 32'h0,        8'd9},
    '{1'b0, 3'd1, 32'h0,        32'h0004AA7F, 8'd9}, // R9 pin addr write ignored
    '{1'b1, 3'd7, 32'hFFFFFFFF, 32'h0,        8'd9},
    '{1'b0, 3'd1, 32'h0,        32'h0004AA7F, 8'd9}, // R9 unmapped write ignored
    '{1'b0, 3'd0, 32'h0,        32'hFFFF0000, 8'd9}, // R9 direction unchanged
    '{1'b0, 3'd7, 32'h0,        32'h0,        8'd9}  // R9 unmapped reads 0
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    logic [W-1:0] rd;
    // R1: state while reset is held
    repeat (2) @(negedge clk);
    check("R1 oe in reset", pin_oe, '0);
    check("R1 out in reset", pin_out, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(3'd0, rd); check("R1 dir after reset", rd, '0);
    bus_read(3'd1, rd); check("R1 out after reset", rd, '0);
    bus_read(3'd3, rd); check("R1 mask after reset", rd, '0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].data);
      else begin
        bus_read(VEC[i].addr, rd);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].exp);
      end
    end

    // R7: pin outputs gated by direction
    @(negedge clk); #2;
    check("R7 pin_oe", pin_oe, 32'hFFFF0000);
    check("R7 pin_out", pin_out, 32'h00040000);

    // R8: two-edge synchronizer latency
    @(negedge clk);
    pin_in = 32'h5A5A1234;
    bus_sel = 1'b0; bus_addr = 3'd2;
    @(negedge clk); #2;
    check("R8 one edge old level", bus_rdata, 32'h0);
    @(negedge clk); #2;
    check("R8 two edges new level", bus_rdata, 32'h5A5A1234);
    // R6: masked read, mask FFFF00FF
    bus_read(3'd4, rd); check("R6 masked pin read", rd, 32'h00001200);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R1 oe after async reset", pin_oe, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(3'd1, rd); check("R1 out after second reset", rd, '0);
    bus_read(3'd3, rd); check("R1 mask after second reset", rd, '0);

    // R5: mask all-zero means full masked write
    bus_write(3'd4, 32'hC3C3C3C3);
    bus_read(3'd1, rd); check("R5 zero mask full write", rd, 32'hC3C3C3C3);
    // R3/R4: set and clear with all-ones
    bus_write(3'd5, 32'hFFFFFFFF);
    bus_read(3'd1, rd); check("R3 set all", rd, 32'hFFFFFFFF);
    bus_write(3'd6, 32'h0000FFFF);
    bus_read(3'd1, rd); check("R4 clear low half", rd, 32'hFFFF0000);

    done = 1'b1;
    summary();
  end
endmodule